// File: doc/BRIEF.md
# Dual-Edge ADC Sample Rebuilder

A multi-channel high-speed converter sends each sample over a narrow parallel bus on which every pin carries two bits per sample clock: one bit during the high half of the clock and one during the low half. This block catches each pin on both clock edges and moves the low-phase bits into the rising-edge domain. It then joins each pin's two bits into one full-width word per channel and sends that word out with a valid flag. Converters differ in which half of the clock carries the odd bits. A board may also shift one phase by half a clock against the other. Two runtime controls per channel correct both cases, so the bits of one sample always end up in the same word.

The block serves four identical lanes by default. Each lane has its own polarity control, its own extra-stage control and its own valid output. A lane's valid output stays low until its pipeline holds only data captured under its current settings. An asynchronous active-low reset clears every capture and pipeline register at once. The reset is released through a two-stage synchronizer.

Top module: `ddr_sample_rebuild`

## Requirements
- R1: For each lane c, pin k of din (bit c*PINS+k) is captured at every rising and every falling clock edge. Output bits 2k (even) and 2k+1 (odd) of the lane's 2*PINS-bit slice sample_o[c*2*PINS +: 2*PINS] carry the two phases of that pin.
- R2: With odd_on_fall[c]=0, bit 2k+1 takes the rising-edge capture and bit 2k takes the falling-edge capture. With odd_on_fall[c]=1 the two are swapped.
- R3: With extra_stage[c]=0, a word pairs the falling-edge bits with the rising edge that follows them. A rising-edge capture taken at edge m appears on sample_o after edge m+2, together with the falling capture taken just after edge m-1.
- R4: With extra_stage[c]=1, a word pairs the rising-edge bits with the falling edge that follows them. A rising-edge capture taken at edge m appears on sample_o after edge m+3, together with the falling capture taken just after edge m.
- R5: The latency in R3 and R4 is the same for both polarity settings.
- R6: While rst_n is low, every valid_o bit and every sample_o bit is 0, including at once after rst_n falls between clock edges.
- R7: With all controls at 0 when reset is released, valid_o stays low and rises after rising edge number 5, counting edge 1 as the first rising edge that samples rst_n high.
- R8: When a lane's controls change, its valid_o is low after the first rising edge that samples the new value (edge k). It comes back after edge k+D+1 (D=2 without the extra stage, 3 with it), and the data it then flags is paired under the new settings.
- R9: A control change on one lane leaves the valid_o and sample_o behaviour of every other lane unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; data is captured on both edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| odd_on_fall | input | NUM_CH | Per lane: 1 puts the falling-edge bits in the odd positions |
| extra_stage | input | NUM_CH | Per lane: 1 adds a rising-path stage (rising-first pairing) |
| din | input | NUM_CH*PINS | Dual-edge data pins, PINS per lane |
| sample_o | output | NUM_CH*2*PINS | Rebuilt words, 2*PINS bits per lane |
| valid_o | output | NUM_CH | Per-lane flag: sample_o slice holds a correctly paired word |

## Verification
The hardest case to reach from the ports is a settings change on one lane while the other lanes keep streaming. A wrong design can leak the old pairing through the pipeline for one word, or disturb its neighbours. The bench drives new falling-phase data just after each rising edge and new rising-phase data just after each falling edge, so every capture is known by edge and phase. It changes one lane's extra-stage setting between edges and then checks that lane's valid gap and first paired word against the edge history. In the same cycles it checks that the other lanes keep streaming without a break. A reset asserted mid-stream is checked at once between edges, and again through the synchronized release.

// File: rtl/ddr_rebuild_pkg.sv
`timescale 1ns/1ps
package ddr_rebuild_pkg;
  // depth of the rising path without the optional stage
  localparam int unsigned BASE_DEPTH  = 2;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic odd_on_fall;
    logic extra_stage;
  } lane_cfg_t;

  function automatic int unsigned lane_depth(input logic extra);
    return extra ? BASE_DEPTH + 1 : BASE_DEPTH;
  endfunction
endpackage

// File: rtl/ddr_rst_sync.sv
`timescale 1ns/1ps
module ddr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ddr_phase_capture.sv
`timescale 1ns/1ps
module ddr_phase_capture #(
  parameter int unsigned PINS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            extra_stage,
  input  logic [PINS-1:0] din,
  output logic [PINS-1:0] rise_o,
  output logic [PINS-1:0] fall_o
);
  logic [PINS-1:0] rise_q, rise_x_q, fall_q, fall_rt_q;
  logic [PINS-1:0] rise_d, rise_x_d, fall_d, fall_rt_d;
  logic            cap_en;

  // capture runs every cycle; enable kept explicit for clock gating
  assign cap_en = 1'b1;

  always_comb begin
    rise_d    = din;
    fall_d    = din;
    fall_rt_d = fall_q;     // move low-phase bits to the rising domain
    rise_x_d  = rise_q;     // optional extra rising stage
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q    <= '0;
      rise_x_q  <= '0;
      fall_rt_q <= '0;
    end else if (cap_en) begin
      rise_q    <= rise_d;
      rise_x_q  <= rise_x_d;
      fall_rt_q <= fall_rt_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      fall_q <= '0;
    else if (cap_en) fall_q <= fall_d;
  end

  always_comb begin
    rise_o = extra_stage ? rise_x_q : rise_q;
    fall_o = fall_rt_q;
  end
endmodule

// File: rtl/ddr_phase_merge.sv
`timescale 1ns/1ps
module ddr_phase_merge #(
  parameter int unsigned PINS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              odd_on_fall,
  input  logic [PINS-1:0]   rise_i,
  input  logic [PINS-1:0]   fall_i,
  output logic [2*PINS-1:0] word_o
);
  localparam int unsigned W = 2 * PINS;

  logic [W-1:0] pair_d, pair_q, out_q;

  for (genvar k = 0; k < PINS; k++) begin : g_pin
    assign pair_d[2*k+1] = odd_on_fall ? fall_i[k] : rise_i[k];
    assign pair_d[2*k]   = odd_on_fall ? rise_i[k] : fall_i[k];
  end

  // pair register, then one buffer stage before the port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
      out_q  <= '0;
    end else begin
      pair_q <= pair_d;
      out_q  <= pair_q;
    end
  end

  assign word_o = out_q;
endmodule

// File: rtl/ddr_fill_track.sv
`timescale 1ns/1ps
module ddr_fill_track
  import ddr_rebuild_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lane_cfg_t cfg_i,
  output logic      valid_o
);
  localparam int unsigned FILL_MAX = BASE_DEPTH + 2;
  localparam int unsigned CNT_W    = $clog2(FILL_MAX + 1);

  lane_cfg_t        cfg_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, target;
  logic             cfg_chg, cnt_en;

  always_comb begin
    target  = CNT_W'(lane_depth(cfg_q.extra_stage) + 1);
    cfg_chg = (cfg_i != cfg_q);
    cnt_en  = (cnt_q != target);
    cnt_d   = cnt_q;
    if (cfg_chg)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      cfg_q <= cfg_i;
      cnt_q <= cnt_d;
    end
  end

  assign valid_o = (cnt_q == target);
endmodule

// File: rtl/ddr_sample_rebuild.sv
`timescale 1ns/1ps
module ddr_sample_rebuild
  import ddr_rebuild_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned PINS   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          odd_on_fall,
  input  logic [NUM_CH-1:0]          extra_stage,
  input  logic [NUM_CH*PINS-1:0]     din,
  output logic [NUM_CH*2*PINS-1:0]   sample_o,
  output logic [NUM_CH-1:0]          valid_o
);
  localparam int unsigned SW = 2 * PINS;

  logic rst_int_n;

  ddr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic [PINS-1:0] rise_w, fall_w;
    lane_cfg_t       cfg_w;

    assign cfg_w = {odd_on_fall[c], extra_stage[c]};

    ddr_phase_capture #(.PINS(PINS)) u_cap (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .extra_stage (extra_stage[c]),
      .din         (din[c*PINS +: PINS]),
      .rise_o      (rise_w),
      .fall_o      (fall_w)
    );

    ddr_phase_merge #(.PINS(PINS)) u_merge (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .odd_on_fall (odd_on_fall[c]),
      .rise_i      (rise_w),
      .fall_i      (fall_w),
      .word_o      (sample_o[c*SW +: SW])
    );

    ddr_fill_track u_fill (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .cfg_i   (cfg_w),
      .valid_o (valid_o[c])
    );
  end
endmodule

// File: rtl/ddr_sample_rebuild_chk.sv
`timescale 1ns/1ps
module ddr_sample_rebuild_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned PINS   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CH-1:0]        odd_on_fall,
  input logic [NUM_CH-1:0]        extra_stage,
  input logic [NUM_CH*PINS-1:0]   din,
  input logic [NUM_CH*2*PINS-1:0] sample_o,
  input logic [NUM_CH-1:0]        valid_o
);
  localparam int unsigned SW = 2 * PINS;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R7: no valid on the first edge after reset release
    assert_release_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !valid_o[c]);

    // R8: valid only rises with settings held steady
    assert_fill_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o[c]) |-> ($stable(odd_on_fall[c]) && $stable(extra_stage[c])));

    // R8: a settings change drops valid on the next edge
    assert_cfg_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(odd_on_fall[c]) || !$stable(extra_stage[c])) |=> !valid_o[c]);

    for (genvar p = 0; p < PINS; p++) begin : g_pin
      // R3: odd bit is the rising capture, three samples back
      assert_odd_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o[c] && $stable(odd_on_fall[c]) && $stable(extra_stage[c]) &&
         !odd_on_fall[c] && !extra_stage[c])
        |-> sample_o[c*SW + 2*p + 1] == $past(din[c*PINS + p], 3));

      // R2 and R5: swapped polarity, same latency
      assert_even_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o[c] && $stable(odd_on_fall[c]) && $stable(extra_stage[c]) &&
         odd_on_fall[c] && !extra_stage[c])
        |-> sample_o[c*SW + 2*p] == $past(din[c*PINS + p], 3));

      // R4: extra stage adds one cycle on the rising path
      assert_extra_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o[c] && $stable(odd_on_fall[c]) && $stable(extra_stage[c]) &&
         odd_on_fall[c] && extra_stage[c])
        |-> sample_o[c*SW + 2*p] == $past(din[c*PINS + p], 4));
    end
  end
endmodule

bind ddr_sample_rebuild ddr_sample_rebuild_chk #(.NUM_CH(NUM_CH), .PINS(PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .odd_on_fall (odd_on_fall),
  .extra_stage (extra_stage),
  .din         (din),
  .sample_o    (sample_o),
  .valid_o     (valid_o)
);

// File: tb/ddr_sample_rebuild_tb.sv
`timescale 1ns/1ps
module ddr_sample_rebuild_tb;
  localparam int NUM_CH = 4;
  localparam int PINS   = 5;
  localparam int W      = NUM_CH * PINS;
  localparam int SW     = 2 * PINS;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NUM_CH-1:0]    odd_on_fall, extra_stage;
  logic [W-1:0]         din;
  logic [NUM_CH*SW-1:0] sample_o;
  logic [NUM_CH-1:0]    valid_o;

  ddr_sample_rebuild #(.NUM_CH(NUM_CH), .PINS(PINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .odd_on_fall(odd_on_fall), .extra_stage(extra_stage),
    .din(din), .sample_o(sample_o), .valid_o(valid_o)
  );

  always #10 clk = ~clk;

  int ecnt = 0;
  always @(posedge clk) ecnt++;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0]      rise_h [16];
  logic [W-1:0]      fall_h [16];
  logic [NUM_CH-1:0] pol_r, ext_r;
  int                chg [NUM_CH];
  int                rstart;
  bit                in_rst;

  function automatic logic [W-1:0] gen(input int patt, input int m, input bit rise);
    case (patt)
      1:       return rise ? '1 : '0;
      2:       return W'(m * 7) ^ (rise ? W'(32'h5a5a5) : W'(32'h3c3c3));
      default: return W'($urandom);
    endcase
  endfunction

  function automatic logic [SW-1:0] exp_word(input int c, input logic [W-1:0] r,
                                             input logic [W-1:0] f, input logic pol);
    logic [SW-1:0] w;
    for (int k = 0; k < PINS; k++) begin
      w[2*k+1] = pol ? f[c*PINS+k] : r[c*PINS+k];
      w[2*k]   = pol ? r[c*PINS+k] : f[c*PINS+k];
    end
    return w;
  endfunction

  task automatic check_edge(input int m, input string tag);
    for (int c = 0; c < NUM_CH; c++) begin
      logic [SW-1:0] act;
      act = sample_o[c*SW +: SW];
      if (in_rst) begin
        checks++;
        if (valid_o[c] !== 1'b0 || act !== '0) begin
          fails++;
          $display("FAIL R6 lane %0d edge %0d: valid=%b word=%h expected valid=0 word=0",
                   c, m, valid_o[c], act);
        end
      end else begin
        int  d, st;
        bit  vexp;
        string tv;
        d    = ext_r[c] ? 3 : 2;
        st   = (chg[c] > rstart) ? chg[c] : rstart;
        vexp = (m >= st + d + 1);
        tv   = (m < rstart + d + 1) ? "R7" : tag;
        checks++;
        if (valid_o[c] !== vexp) begin
          fails++;
          $display("FAIL %s lane %0d edge %0d: valid=%b expected %b", tv, c, m, valid_o[c], vexp);
        end
        if (vexp) begin
          int r, f;
          logic [SW-1:0] e;
          r = ext_r[c] ? m - 3 : m - 2;
          f = m - 3;
          e = exp_word(c, rise_h[r % 16], fall_h[f % 16], pol_r[c]);
          checks++;
          if (act !== e) begin
            fails++;
            $display("FAIL %s lane %0d edge %0d: word=%h expected %h", tag, c, m, act, e);
          end
        end
      end
    end
  endtask

  // one rising edge: check it, then drive low-phase data and next high-phase data
  task automatic step(input logic [NUM_CH-1:0] np, input logic [NUM_CH-1:0] ne,
                      input int patt, input string tag, input bit rel = 1'b0);
    int m;
    logic [W-1:0] v;
    @(posedge clk); #2;
    m = ecnt;
    check_edge(m, tag);
    #1;
    v = gen(patt, m, 1'b0);
    fall_h[m % 16] = v;
    din = v;
    @(negedge clk); #2;
    v = gen(patt, m + 1, 1'b1);
    rise_h[(m + 1) % 16] = v;
    din = v;
    for (int c = 0; c < NUM_CH; c++)
      if (np[c] !== pol_r[c] || ne[c] !== ext_r[c]) chg[c] = m + 1;
    pol_r = np; ext_r = ne;
    odd_on_fall = np; extra_stage = ne;
    if (rel) begin
      rst_n  = 1'b1;
      in_rst = 1'b0;
      rstart = m + 2;
    end
  endtask

  task automatic check_reset_now();
    checks++;
    if (valid_o !== '0 || sample_o !== '0) begin
      fails++;
      $display("FAIL R6 async clear: valid=%b word=%h expected 0/0", valid_o, sample_o);
    end
  endtask

  task automatic t_power_on();
    for (int i = 0; i < 3; i++) step('0, '0, 0, "R6");
    step('0, '0, 0, "R7", 1'b1);
    for (int i = 0; i < 10; i++) step('0, '0, 0, "R1");
  endtask

  task automatic t_alternating();
    for (int i = 0; i < 6; i++) step('0, '0, 1, "R3");
    for (int i = 0; i < 6; i++) step('0, '0, 2, "R3");
  endtask

  task automatic t_polarity();
    for (int i = 0; i < 10; i++) step('1, '0, 0, "R2");
    for (int i = 0; i < 6; i++)  step('1, '0, 1, "R5");
  endtask

  task automatic t_extra();
    for (int i = 0; i < 10; i++) step('0, '1, 0, "R4");
    for (int i = 0; i < 10; i++) step('1, '1, 2, "R4");
  endtask

  task automatic t_one_lane();
    step(4'b1111, 4'b1111, 0, "R8/R9");
    step(4'b1111, 4'b1101, 0, "R8/R9");
    for (int i = 0; i < 8; i++) step(4'b1111, 4'b1101, 0, "R8/R9");
    step(4'b1011, 4'b1101, 0, "R8/R9");
    for (int i = 0; i < 8; i++) step(4'b1011, 4'b1101, 0, "R8/R9");
  endtask

  task automatic t_mid_reset();
    rst_n  = 1'b0;
    in_rst = 1'b1;
    #1;
    check_reset_now();
    for (int i = 0; i < 3; i++) step('0, '0, 0, "R6");
    step('0, '0, 0, "R7", 1'b1);
    for (int i = 0; i < 10; i++) step('0, '0, 2, "R7");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_rst = 1'b1; rstart = 0;
    din = '0; odd_on_fall = '0; extra_stage = '0;
    pol_r = '0; ext_r = '0;
    for (int c = 0; c < NUM_CH; c++) chg[c] = 0;
    t_power_on();
    t_alternating();
    t_polarity();
    t_extra();
    t_one_lane();
    t_mid_reset();
    finish_run();
  end
endmodule